// File: doc/BRIEF.md
# Cascadable Serial Result Readout Port

This block is the serial slave readout side of a 16-bit sampling converter. When a conversion ends, a conversion sequencer lowers its busy indication and the block captures the parallel result. An external host then reads that word one bit at a time. It selects the port with chip select and read strobe and supplies a serial clock. The port sends the word on a single data pin, most significant bit first. The port only follows the external clock while an external-clock mode input is HIGH.

Several ports can be cascaded. The serial data output of one port connects to the chain input of the next port downstream. The chain input is captured on the serial clock edge opposite to the one that advances the output, so the upstream word follows the local least significant bit with no idle slot. An invert input picks which clock polarity advances the data. The idle level of the clock can therefore be HIGH or LOW.

All pins are brought into the block's own clock domain through synchronizers. Serial clock edges are detected there. The external serial clock must therefore toggle well below half the block clock rate.

Top module: `chain_serial_port`

## Requirements
- R1: While `ext_clk_en` is LOW, `sdo` is held at 0 and serial clock edges cause no output activity.
- R2: `sdo` carries data only while both `cs_n` and `rd_n` are LOW. Otherwise it rests at 0 and clock edges do not advance the word.
- R3: A falling edge of `busy` captures `result` for readout. While `busy` is HIGH, serial clock edges neither advance nor alter the bit on `sdo`.
- R4: With `inv_sclk` = 0, the most significant bit is on `sdo` before any clock edge. Each falling edge of `sclk` moves the output to the next lower bit, so 16 pulses present bits 15 down to 0.
- R5: With `inv_sclk` = 1, rising edges of `sclk` advance the output and the word still leaves most significant bit first.
- R6: `chain_in` is sampled on the clock edge opposite to the advancing edge. Sampled bits follow the local bit 0 in arrival order, so output bit 17 of a read is the first sampled chain bit.
- R7: Each new read (`cs_n` and `rd_n` both becoming LOW) restarts the bit count and presents the held word from its most significant bit again.
- R8: A `busy` falling edge during a partly shifted read leaves the rest of that read on the old word. The new word is taken once the read ends and appears on the next read.
- R9: The bit on `sdo` does not change across the non-advancing edge of a pulse, so a host may capture on either edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to sample all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_clk_en | input | 1 | HIGH enables the external serial clock mode |
| inv_sclk | input | 1 | 0: falling edge advances the output; 1: rising edge advances it |
| sclk | input | 1 | External serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| busy | input | 1 | HIGH during conversion; its falling edge marks a new result |
| result | input | 16 | Parallel conversion result |
| chain_in | input | 1 | Serial input from the upstream port of a cascade |
| sdo | output | 1 | Serial data output |

## Verification
The word is read with both clock polarities, using asymmetric patterns such as 0xA5C3 and 0x1234. A reversed bit order or a wrong advancing edge shows up as a different word. A 32-pulse read with a distinct upstream word on the chain input checks that the cascade follows bit 0 with no gap and no extra slot. Short reads of 4 and 5 bits followed by a new read separate a restart from a resumed read. A conversion that ends in the middle of a read checks both the freeze while busy and the deferred load of the new word. Reads with the mode pin LOW, with only one strobe low and held in reset check the idle level of the output.

// File: rtl/srp_pkg.sv
package srp_pkg;
  // Per-cycle serial clock events after polarity selection
  typedef struct packed {
    logic adv;  // edge that moves the output to the next bit
    logic cap;  // opposite edge, samples the cascade input
  } sclk_ev_t;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned WORD_W      = 16;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    logic [STAGES-1:0] ff_n;

    if (STAGES > 1) begin : g_multi
      always_comb ff_n = {ff_q[STAGES-2:0], d[b]};
    end else begin : g_single
      always_comb ff_n = d[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[b]}};
      else        ff_q <= ff_n;
    end

    assign q[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/srp_edge_gen.sv
module srp_edge_gen
  import srp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     inv,
  input  logic     en,
  output sclk_ev_t ev
);
  logic prev_q;
  logic rise, fall;

  always_comb begin
    rise   = sclk_s & ~prev_q;
    fall   = ~sclk_s & prev_q;
    ev.adv = en & (inv ? rise : fall);
    ev.cap = en & (inv ? fall : rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_s;
  end

  // An advance needs two transitions of the pin, so two never abut (R5)
  p_adv_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.adv |=> !ev.adv);

  // A disabled port sees no clock events (R1)
  p_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(ev.adv || ev.cap));
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter
  import srp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         busy,
  input  sclk_ev_t     ev,
  input  logic         chain,
  input  logic [W-1:0] result,
  output logic         sdo
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic [W-1:0]  sh_q, sh_n;
  logic [W-1:0]  word_q, word_n;
  logic [W-1:0]  stash_q, stash_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          hold_q, hold_n;
  logic          pend_q, pend_n;
  logic          busy_q, act_q;

  logic busy_fall, start, load_ok, shift_ok, cap_ok;

  // Event decode
  always_comb begin
    busy_fall = busy_q & ~busy;
    start     = active & ~act_q;
    load_ok   = pend_q & (~active | (cnt_q == '0));
    shift_ok  = ev.adv & active & ~busy & ~start & ~load_ok;
    cap_ok    = ev.cap & active & ~busy;
  end

  // Next state
  always_comb begin
    stash_n = busy_fall ? result : stash_q;
    pend_n  = busy_fall ? 1'b1 : (load_ok ? 1'b0 : pend_q);
    word_n  = load_ok ? stash_q : word_q;
    hold_n  = cap_ok ? chain : hold_q;

    if (load_ok)       sh_n = stash_q;
    else if (start)    sh_n = word_q;
    else if (shift_ok) sh_n = {sh_q[W-2:0], hold_q};
    else               sh_n = sh_q;

    if (load_ok || start)                 cnt_n = '0;
    else if (shift_ok && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
    else                                   cnt_n = cnt_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      word_q  <= '0;
      stash_q <= '0;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
      busy_q  <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      sh_q    <= sh_n;
      word_q  <= word_n;
      stash_q <= stash_n;
      cnt_q   <= cnt_n;
      hold_q  <= hold_n;
      pend_q  <= pend_n;
      busy_q  <= busy;
      act_q   <= active;
    end
  end

  assign sdo = active & sh_q[W-1];

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  p_msb_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ok |=> sh_q[W-1] == $past(sh_q[W-2]));

  p_busy_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !load_ok) |=> $stable(sh_q));

  p_defer_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && act_q && cnt_q != '0) |=> $stable(word_q));

  p_restart_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == '0);
endmodule

// File: rtl/chain_serial_port.sv
module chain_serial_port
  import srp_pkg::*;
#(
  parameter int unsigned W      = WORD_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_clk_en,
  input  logic         inv_sclk,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         busy,
  input  logic [W-1:0] result,
  input  logic         chain_in,
  output logic         sdo
);
  localparam int unsigned NSYNC = 6;
  // bit order: {chain, busy, rd_n, cs_n, mode, sclk}
  localparam logic [NSYNC-1:0] SYNC_RST = 6'b001100;

  logic [1:0] rst_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ns = rst_q[1];

  logic [NSYNC-1:0] pins_s;
  logic sclk_s, mode_s, cs_s, rd_s, busy_s, chain_s, active;
  sclk_ev_t ev;

  srp_sync #(.N(NSYNC), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .d     ({chain_in, busy, rd_n, cs_n, ext_clk_en, sclk}),
    .q     (pins_s)
  );

  always_comb begin
    {chain_s, busy_s, rd_s, cs_s, mode_s, sclk_s} = pins_s;
    active = mode_s & ~cs_s & ~rd_s;
  end

  srp_edge_gen u_edge (
    .clk    (clk),
    .rst_n  (rst_ns),
    .sclk_s (sclk_s),
    .inv    (inv_sclk),
    .en     (mode_s),
    .ev     (ev)
  );

  srp_shifter #(.W(W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_ns),
    .active (active),
    .busy   (busy_s),
    .ev     (ev),
    .chain  (chain_s),
    .result (result),
    .sdo    (sdo)
  );

  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (cs_s || rd_s) |-> !sdo);

  p_mode_off_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !mode_s |-> !sdo);
endmodule

// File: tb/tb_chain_serial_port.sv
module tb_chain_serial_port;
  logic        clk, rst_n, ext_clk_en, inv_sclk, sclk, cs_n, rd_n, busy, chain_in;
  logic [15:0] result;
  logic        sdo;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  chain_serial_port dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_en(ext_clk_en), .inv_sclk(inv_sclk),
    .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .result(result),
    .chain_in(chain_in), .sdo(sdo)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic set_idle(input bit inv);
    inv_sclk = inv;
    sclk = inv;
    wait_clk(8);
  endtask

  task automatic convert(input logic [15:0] w);
    busy = 1; result = w;
    wait_clk(20);
    busy = 0;
    wait_clk(10);
  endtask

  task automatic open_read();
    cs_n = 0; rd_n = 0;
    wait_clk(10);
  endtask

  task automatic close_read();
    cs_n = 1; rd_n = 1;
    wait_clk(10);
  endtask

  // sample, non-advancing edge, sample, advancing edge
  task automatic pulse(output logic pre, output logic mid);
    pre = sdo;
    sclk = ~sclk;
    wait_clk(8);
    mid = sdo;
    sclk = ~sclk;
    wait_clk(8);
  endtask

  task automatic read_bits(input int n, output logic [31:0] got);
    logic p, m;
    got = '0;
    for (int i = 0; i < n; i++) begin
      pulse(p, m);
      check(p === m, "R9 bit steady across capture edge", {31'd0, m}, {31'd0, p});
      got = {got[30:0], p};
    end
  endtask

  task automatic t_reset();
    check(sdo === 1'b0, "R2 reset idle level", {31'd0, sdo}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] g;
    set_idle(0);
    convert(16'hA5C3);
    open_read();
    read_bits(16, g);
    check(g[15:0] === 16'hA5C3, "R4 MSB first, falling edge advance", g, 32'hA5C3);
    check(g[15:0] === 16'hA5C3, "R3 result captured at busy fall", g, 32'hA5C3);
    close_read();
  endtask

  task automatic t_inv();
    logic [31:0] g;
    set_idle(1);
    convert(16'h1234);
    open_read();
    read_bits(16, g);
    check(g[15:0] === 16'h1234, "R5 rising edge advance", g, 32'h1234);
    close_read();
    set_idle(0);
  endtask

  task automatic t_chain();
    logic [15:0] up;
    logic [31:0] g;
    logic p, m;
    up = 16'hB00D;
    convert(16'h8E71);
    open_read();
    g = '0;
    for (int k = 0; k < 32; k++) begin
      chain_in = (k < 16) ? up[15-k] : 1'b0;
      wait_clk(2);
      pulse(p, m);
      g = {g[30:0], p};
    end
    chain_in = 0;
    check(g === {16'h8E71, up}, "R6 cascade word follows LSB", g, {16'h8E71, up});
    close_read();
  endtask

  task automatic t_restart();
    logic [31:0] g;
    convert(16'h6C35);
    open_read();
    read_bits(5, g);
    check(g[4:0] === 5'b01101, "R7 partial read head", g, 32'h0D);
    close_read();
    open_read();
    read_bits(16, g);
    check(g[15:0] === 16'h6C35, "R7 new read restarts at MSB", g, 32'h6C35);
    close_read();
  endtask

  task automatic t_defer();
    logic [31:0] g;
    logic p, m;
    convert(16'h0F0F);
    open_read();
    read_bits(4, g);
    check(g[3:0] === 4'h0, "R8 first nibble of old word", g, 0);
    busy = 1; result = 16'hABCD;
    wait_clk(10);
    for (int i = 0; i < 2; i++) begin
      pulse(p, m);
      check(p === 1'b1 && m === 1'b1, "R3 edges ignored while busy",
            {30'd0, p, m}, 32'h3);
    end
    check(sdo === 1'b1, "R3 bit held after busy pulses", {31'd0, sdo}, 1);
    busy = 0;
    wait_clk(10);
    read_bits(12, g);
    check(g[11:0] === 12'hF0F, "R8 read finishes on old word", g, 32'hF0F);
    close_read();
    open_read();
    read_bits(16, g);
    check(g[15:0] === 16'hABCD, "R8 new word on next read", g, 32'hABCD);
    close_read();
  endtask

  task automatic t_gate();
    logic p, m;
    convert(16'hFFFF);
    ext_clk_en = 0;
    open_read();
    for (int i = 0; i < 3; i++) begin
      pulse(p, m);
      check(p === 0 && m === 0, "R1 mode off holds sdo low", {30'd0, p, m}, 0);
    end
    close_read();
    ext_clk_en = 1;
    wait_clk(8);
    cs_n = 1; rd_n = 0;
    wait_clk(10);
    pulse(p, m);
    check(p === 0 && m === 0, "R2 chip select high idles sdo", {30'd0, p, m}, 0);
    cs_n = 0; rd_n = 1;
    wait_clk(10);
    pulse(p, m);
    check(p === 0 && m === 0, "R2 read strobe high idles sdo", {30'd0, p, m}, 0);
    close_read();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; ext_clk_en = 1; inv_sclk = 0; sclk = 0; cs_n = 1; rd_n = 1;
    busy = 0; result = '0; chain_in = 0;
    wait_clk(6);
    t_reset();
    rst_n = 1;
    wait_clk(6);
    t_reset();
    t_basic();
    t_inv();
    t_chain();
    t_restart();
    t_defer();
    t_gate();
    done = 1;
    finish_run();
  end
endmodule